// File: doc/BRIEF.md
# Twin-Port Word Memory with Per-Port Write Hold

This block is a memory of 2048 bytes with two ports, called the left port (A) and the right port (B). Each port has its own select, direction strobe, output enable, 11-bit address and 8-bit data path. Either port can reach any word in any cycle. Both ports can work on different words, or on the same word, in the same clock.

The bidirectional data bus of each port is split into three signals: write data in, registered read data out, and a registered drive flag. A pad ring or bus wrapper uses the drive flag to turn its tri-state buffer on or off.

Each port also has an active-low hold input. An arbiter outside the block drives it. While a port's hold input is low, a write from that port is dropped without any signal. A read from that port still completes.

Reads are synchronous: the data appears one clock after the address is presented. When one port reads a word that the other port is committing in the same cycle, the read returns the new data. When both ports commit a write to the same word in the same cycle, the left port's data is stored.

Top module: `twin_port_ram`

## Requirements
- R1: The memory holds 2^AW words of DW bits (2048 x 8 by default). A word written at any address, including 0 and 0x7FF, is read back unchanged.
- R2: A port writes its data into the addressed word at the clock edge when sel_n=0, rw=0 and hold_n=1.
- R3: When sel_n=0, rw=1 and oe_n=0 at an edge, the port's drive output is 1 after that edge, and its rdata then shows the addressed word.
- R4: The port's drive output is 0 after any edge where sel_n=1, oe_n=1 or rw=0.
- R5: A write from a port whose hold_n is 0 leaves the memory unchanged.
- R6: hold_n=0 does not block reads. A read on that port still returns the stored word.
- R7: A read from one port at the same address as a write committed by the other port in the same cycle returns the newly written data.
- R8: When both ports commit a write to the same address in the same cycle, the left port's data is stored. When the left write is held (hold_n=0), the right port's data is stored.
- R9: With sel_n=1 a port does not touch the memory, and its rdata keeps its previous value. rdata also keeps its value whenever the port is not reading.
- R10: Synchronous active-high reset clears both drive outputs and both rdata outputs to 0. The memory contents are not reset.
- R11: The two ports act independently. Two accesses at different addresses in the same cycle both complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_sel_n | input | 1 | Left port select, active low |
| a_rw | input | 1 | Left port direction: 1 read, 0 write |
| a_oe_n | input | 1 | Left port output enable, active low |
| a_hold_n | input | 1 | Left port write hold, active low |
| a_addr | input | AW | Left port word address |
| a_wdata | input | DW | Left port write data |
| a_rdata | output | DW | Left port registered read data |
| a_drive | output | 1 | Left port bus drive enable |
| b_sel_n | input | 1 | Right port select, active low |
| b_rw | input | 1 | Right port direction: 1 read, 0 write |
| b_oe_n | input | 1 | Right port output enable, active low |
| b_hold_n | input | 1 | Right port write hold, active low |
| b_addr | input | AW | Right port word address |
| b_wdata | input | DW | Right port write data |
| b_rdata | output | DW | Right port registered read data |
| b_drive | output | 1 | Right port bus drive enable |

## Verification
The hardest case to reach is a write collision on one word in a single cycle, under every combination of hold inputs. A dropped write leaves no trace at the ports. So the stimulus pairs each colliding or held write with a read of the same word from the other port. It does this both in the same cycle, to exercise the bypass path, and in the following cycle, to see what was stored. It also walks both collision outcomes: both holds high, and only the left hold low.

// File: rtl/tpr_pkg.sv
package tpr_pkg;
  typedef struct packed {
    logic we;   // committed write this cycle
    logic re;   // array read this cycle
    logic drv;  // port should drive its bus next cycle
  } port_cmd_t;
endpackage

// File: rtl/tpr_port_ctl.sv
module tpr_port_ctl (
  input  logic                clk,
  input  logic                rst,
  input  logic                sel_n,
  input  logic                rw,
  input  logic                oe_n,
  input  logic                hold_n,
  output tpr_pkg::port_cmd_t  cmd,
  output logic                drive
);
  logic active;

  always_comb begin
    active  = ~sel_n;
    cmd.we  = active & ~rw & hold_n;
    cmd.re  = active & rw;
    cmd.drv = active & rw & ~oe_n;
  end

  always_ff @(posedge clk) begin
    if (rst) drive <= 1'b0;
    else     drive <= cmd.drv;
  end
endmodule

// File: rtl/tpr_array.sv
module tpr_array #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wd,
  output logic [DW-1:0] a_q,
  input  logic          b_we,
  input  logic          b_re,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wd,
  output logic [DW-1:0] b_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic          same_word;
  logic          b_we_eff;

  assign same_word = (a_addr == b_addr);
  // left port has priority on a same-word collision
  assign b_we_eff  = b_we & ~(a_we & same_word);

  always_ff @(posedge clk) begin
    if (b_we_eff) store[b_addr] <= b_wd;
    if (a_we)     store[a_addr] <= a_wd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_re) a_q <= (b_we_eff && same_word) ? b_wd : store[a_addr];
      if (b_re) b_q <= (a_we && same_word) ? a_wd : store[b_addr];
    end
  end
endmodule

// File: rtl/twin_port_ram.sv
module twin_port_ram #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_sel_n,
  input  logic          a_rw,
  input  logic          a_oe_n,
  input  logic          a_hold_n,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  output logic          a_drive,
  input  logic          b_sel_n,
  input  logic          b_rw,
  input  logic          b_oe_n,
  input  logic          b_hold_n,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata,
  output logic          b_drive
);
  tpr_pkg::port_cmd_t a_cmd, b_cmd;

  tpr_port_ctl u_ctl_a (
    .clk(clk), .rst(rst), .sel_n(a_sel_n), .rw(a_rw), .oe_n(a_oe_n),
    .hold_n(a_hold_n), .cmd(a_cmd), .drive(a_drive)
  );

  tpr_port_ctl u_ctl_b (
    .clk(clk), .rst(rst), .sel_n(b_sel_n), .rw(b_rw), .oe_n(b_oe_n),
    .hold_n(b_hold_n), .cmd(b_cmd), .drive(b_drive)
  );

  tpr_array #(.AW(AW), .DW(DW)) u_array (
    .clk(clk), .rst(rst),
    .a_we(a_cmd.we), .a_re(a_cmd.re), .a_addr(a_addr), .a_wd(a_wdata), .a_q(a_rdata),
    .b_we(b_cmd.we), .b_re(b_cmd.re), .b_addr(b_addr), .b_wd(b_wdata), .b_q(b_rdata)
  );
endmodule

// File: rtl/tpr_checker.sv
module tpr_checker #(
  parameter int AW = 11,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          a_sel_n,
  input logic          a_rw,
  input logic          a_oe_n,
  input logic          a_hold_n,
  input logic [AW-1:0] a_addr,
  input logic [DW-1:0] a_wdata,
  input logic [DW-1:0] a_rdata,
  input logic          a_drive,
  input logic          b_sel_n,
  input logic          b_rw,
  input logic          b_oe_n,
  input logic          b_hold_n,
  input logic [AW-1:0] b_addr,
  input logic [DW-1:0] b_wdata,
  input logic [DW-1:0] b_rdata,
  input logic          b_drive
);
  AST_A_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!a_sel_n && a_rw && !a_oe_n) |=> a_drive); // R3
  AST_B_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (rst)
    (!b_sel_n && b_rw && !b_oe_n) |=> b_drive); // R3
  AST_A_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (a_sel_n || !a_rw || a_oe_n) |=> !a_drive); // R4
  AST_B_FLOAT: assert property (@(posedge clk) disable iff (rst)
    (b_sel_n || !b_rw || b_oe_n) |=> !b_drive); // R4
  AST_A_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (a_sel_n || !a_rw) |=> $stable(a_rdata)); // R9
  AST_B_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (b_sel_n || !b_rw) |=> $stable(b_rdata)); // R9
  AST_B_SEES_A_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!a_sel_n && !a_rw && a_hold_n && !b_sel_n && b_rw && a_addr == b_addr)
    |=> b_rdata == $past(a_wdata)); // R7
  AST_A_SEES_B_WRITE: assert property (@(posedge clk) disable iff (rst)
    (!b_sel_n && !b_rw && b_hold_n && !a_sel_n && a_rw && a_addr == b_addr)
    |=> a_rdata == $past(b_wdata)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!a_drive && !b_drive && a_rdata == '0 && b_rdata == '0)); // R10
endmodule

bind twin_port_ram tpr_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_twin_port_ram.sv
module sim_twin_port_ram;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic a_sel_n = 1, a_rw = 1, a_oe_n = 1, a_hold_n = 1;
  logic b_sel_n = 1, b_rw = 1, b_oe_n = 1, b_hold_n = 1;
  logic [10:0] a_addr = '0, b_addr = '0;
  logic [7:0]  a_wdata = '0, b_wdata = '0;
  logic [7:0]  a_rdata, b_rdata;
  logic        a_drive, b_drive;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk; // 125 MHz

  twin_port_ram u0 (.*);

  typedef struct packed {
    logic asn, arw, aoen, ahn; logic [10:0] aa; logic [7:0] ad;
    logic bsn, brw, boen, bhn; logic [10:0] ba; logic [7:0] bd;
    logic ead; logic [7:0] ear; logic ebd; logic [7:0] ebr;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R2 R11: two writes at different words
    '{0,0,1,1,11'h005,8'h11, 0,0,1,1,11'h7FF,8'h22, 0,8'h00,0,8'h00, 4'd2},
    // R11 R3: cross reads
    '{0,1,0,1,11'h7FF,8'h00, 0,1,0,1,11'h005,8'h00, 1,8'h22,1,8'h11, 4'd11},
    // R5: held left write, no bypass
    '{0,0,1,0,11'h005,8'h33, 0,1,0,1,11'h005,8'h00, 0,8'h22,1,8'h11, 4'd5},
    // R6: read with hold low
    '{0,1,0,0,11'h005,8'h00, 1,1,1,1,11'h000,8'h00, 1,8'h11,0,8'h11, 4'd6},
    // R7: right reads word left writes
    '{0,0,1,1,11'h100,8'h44, 0,1,0,1,11'h100,8'h00, 0,8'h11,1,8'h44, 4'd7},
    // R8: collision, both holds high
    '{0,0,1,1,11'h200,8'h55, 0,0,1,1,11'h200,8'h66, 0,8'h11,0,8'h44, 4'd8},
    // R8 R4: left wins; left reads with oe high
    '{0,1,1,1,11'h200,8'h00, 0,1,0,1,11'h200,8'h00, 0,8'h55,1,8'h55, 4'd8},
    // R8: collision, left held
    '{0,0,1,0,11'h300,8'h77, 0,0,1,1,11'h300,8'h88, 0,8'h55,0,8'h55, 4'd8},
    // R9: right deselected with write strobes
    '{0,1,0,1,11'h300,8'h00, 1,0,0,1,11'h300,8'h99, 1,8'h88,0,8'h55, 4'd9},
    // R9: word untouched by deselected port
    '{0,1,0,1,11'h300,8'h00, 0,1,0,1,11'h7FF,8'h00, 1,8'h88,1,8'h22, 4'd9},
    // R5 R4: held right write with oe low
    '{0,1,0,1,11'h7FF,8'h00, 0,0,0,0,11'h7FF,8'hAA, 1,8'h22,0,8'h22, 4'd5},
    // R5: word kept old value
    '{1,1,1,1,11'h000,8'h00, 0,1,0,1,11'h7FF,8'h00, 0,8'h22,1,8'h22, 4'd5}
  };

  task automatic check(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v);
    a_sel_n = v.asn; a_rw = v.arw; a_oe_n = v.aoen; a_hold_n = v.ahn; a_addr = v.aa; a_wdata = v.ad;
    b_sel_n = v.bsn; b_rw = v.brw; b_oe_n = v.boen; b_hold_n = v.bhn; b_addr = v.ba; b_wdata = v.bd;
  endtask

  task automatic idle();
    a_sel_n = 1; a_rw = 1; a_oe_n = 1; a_hold_n = 1;
    b_sel_n = 1; b_rw = 1; b_oe_n = 1; b_hold_n = 1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    check("a_drive reset", 10, {7'd0, a_drive}, 8'h00);
    check("b_drive reset", 10, {7'd0, b_drive}, 8'h00);
    check("a_rdata reset", 10, a_rdata, 8'h00);
    check("b_rdata reset", 10, b_rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      apply(VECS[i]);
      @(negedge clk);
      check($sformatf("vec%0d a_drive", i), int'(VECS[i].req), {7'd0, a_drive}, {7'd0, VECS[i].ead});
      check($sformatf("vec%0d a_rdata", i), int'(VECS[i].req), a_rdata, VECS[i].ear);
      check($sformatf("vec%0d b_drive", i), int'(VECS[i].req), {7'd0, b_drive}, {7'd0, VECS[i].ebd});
      check($sformatf("vec%0d b_rdata", i), int'(VECS[i].req), b_rdata, VECS[i].ebr);
    end
    // R1: boundary address 0 write then read back
    idle();
    a_sel_n = 0; a_rw = 0; a_addr = 11'h000; a_wdata = 8'h5A;
    @(negedge clk);
    idle();
    b_sel_n = 0; b_rw = 1; b_oe_n = 0; b_addr = 11'h000;
    @(negedge clk);
    check("addr0 readback", 1, b_rdata, 8'h5A);
    check("addr0 drive", 3, {7'd0, b_drive}, 8'h01);
    // R10: reset during an active read
    a_sel_n = 0; a_rw = 1; a_oe_n = 0; a_addr = 11'h000;
    rst = 1'b1;
    @(negedge clk);
    check("a_drive in reset", 10, {7'd0, a_drive}, 8'h00);
    check("a_rdata in reset", 10, a_rdata, 8'h00);
    check("b_rdata in reset", 10, b_rdata, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    // R10: memory kept across reset
    check("mem kept after reset", 10, a_rdata, 8'h5A);
    idle();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule